// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block holds the configuration state that decides where system-management memory is visible. Software writes two byte-wide control registers and one 16-bit extended-size register through a dword config-write port with byte enables. From that state the block drives enable levels for five memory windows:

- a legacy low window that normal accesses reach
- a high alias of that low window, opened for normal code
- low and high windows that only SMM accesses reach
- a TSEG blackhole below the top of low memory

For the blackhole it also gives the base and size. A probe port tells the system whether an access would land in the blackhole.

A sticky lock bit clears the open bit and freezes both control registers until reset. The TSEG size field selects one of three fixed sizes, or a size in megabytes that is set by a strap parameter. Firmware learns that strap value by writing a query code to the 16-bit register and reading the register back.

Top module: `smm_ctrl`

## Requirements
- R1: After reset the control register reads 0x00 and the extended register reads 0x00. The size register reads 0xFFFF when EXT_MB > 0 and 0x0000 otherwise. The legacy window is on, every other window is off, and the blackhole is disabled.
- R2: All three registers share one dword at REG_ADDR. Byte 0 is the control register, byte 1 is the extended register, and bytes 2–3 are the size register. Each byte updates only when its byte enable is set. A write to any other dword address has no effect. Writable bits are control [2:0] and extended [3:0]; every other bit of those two registers reads 0.
- R3: When open (control bit 0) is 1, the legacy window equals NOT high-enable (extended bit 3), and the high alias window equals high-enable.
- R4: When open is 0, the legacy window is on and the high alias window is off.
- R5: When global enable (control bit 2) is 1, the SMM low window equals NOT high-enable and the SMM high window equals high-enable. When global enable is 0, both SMM windows are off.
- R6: When TSEG enable (extended bit 0) is 0, the TSEG size is 0. Otherwise the size field (extended bits 2:1) decodes as follows: 00 gives 1 MB, 01 gives 2 MB, 10 gives 8 MB, and 11 gives EXT_MB megabytes.
- R7: The TSEG base equals LOW_TOP minus the size. The blackhole is enabled exactly when the size is nonzero.
- R8: A probe with the SMM flag low hits the blackhole when the address lies in [base, LOW_TOP) and the blackhole is enabled. On a hit the read data is 0xFFFFFFFF. An SMM probe, or an address outside that range, never hits.
- R9: Writing 1 to lock (control bit 1) clears open in the same update. After that, writes to the control and extended registers have no effect. Only reset clears the lock.
- R10: Writing 0xFFFF to the size register while EXT_MB > 0 makes it read back EXT_MB. Any other value, or any value when EXT_MB is 0, reads back as written.
- R11: Register and window outputs change on the clock edge that takes the write, and not before.
- R12: The high alias base output is 0xFEDA0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_addr_i | input | ADDR_W | Config byte address (dword aligned) |
| cfg_be_i | input | 4 | Byte enables |
| cfg_wdata_i | input | 32 | Write data |
| probe_addr_i | input | 32 | Address of an access to classify |
| probe_smm_i | input | 1 | Probe access is made in SMM |
| ctl_o | output | 8 | Control register value |
| ext_o | output | 8 | Extended register value |
| xtseg_o | output | 16 | Extended size register value |
| legacy_win_o | output | 1 | Legacy low window visible to normal accesses |
| high_alias_win_o | output | 1 | Open high alias window enabled |
| high_alias_base_o | output | 32 | Base address of the high alias |
| smm_low_win_o | output | 1 | SMM-only low window enabled |
| smm_high_win_o | output | 1 | SMM-only high window enabled |
| hole_en_o | output | 1 | TSEG blackhole enabled |
| tseg_base_o | output | 32 | TSEG base byte address |
| tseg_size_o | output | 32 | TSEG size in bytes |
| hole_hit_o | output | 1 | Probe falls in the blackhole |
| hole_rdata_o | output | 32 | Read data returned for a probe |

## Verification
The bench builds two copies of the block from the same bus. The first uses EXT_MB = 16 and LOW_TOP = 0x80000000, so the strapped size encoding, the query answer and the blackhole edges at 0x7F800000 and 0x80000000 are all reachable. The second uses EXT_MB = 0, which covers a zero reset value for the size register. With that strap the query code is stored unchanged, and the strapped size encoding produces a disabled blackhole.

// File: rtl/smm_pkg.sv
package smm_pkg;
  localparam int unsigned CTL_OPEN = 0;
  localparam int unsigned CTL_LOCK = 1;
  localparam int unsigned CTL_GEN  = 2;
  localparam int unsigned EXT_TEN  = 0;
  localparam int unsigned EXT_SZ   = 1;
  localparam int unsigned EXT_HIGH = 3;

  localparam logic [7:0]  CTL_WM     = 8'h07;
  localparam logic [7:0]  CTL_WM_LCK = 8'h00;
  localparam logic [7:0]  EXT_WM     = 8'h0F;
  localparam logic [7:0]  EXT_WM_LCK = 8'h00;
  localparam logic [15:0] XT_QUERY   = 16'hFFFF;

  typedef enum logic [1:0] {TSZ_1M = 2'b00, TSZ_2M = 2'b01, TSZ_8M = 2'b10, TSZ_EXT = 2'b11} tseg_sz_e;

  function automatic logic [7:0] merge_byte(logic [7:0] old_v, logic [7:0] new_v, logic [7:0] wm);
    return (old_v & ~wm) | (new_v & wm);
  endfunction
endpackage

// File: rtl/smm_cfg_regs.sv
module smm_cfg_regs
  import smm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h70,
  parameter int unsigned EXT_MB   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [7:0]        ctl_o,
  output logic [7:0]        ext_o,
  output logic [15:0]       xt_o
);
  localparam logic [15:0] XT_RST = (EXT_MB > 0) ? XT_QUERY : 16'h0000;
  localparam logic [15:0] XT_ANS = 16'(EXT_MB);

  logic [7:0]  ctl_q, ctl_n, ext_q, ext_n, ctl_wm, ext_wm;
  logic [15:0] xt_q, xt_n;
  logic        sel;

  assign sel    = we_i && (addr_i[ADDR_W-1:2] == REG_ADDR[ADDR_W-1:2]);
  assign ctl_wm = ctl_q[CTL_LOCK] ? CTL_WM_LCK : CTL_WM;
  assign ext_wm = ctl_q[CTL_LOCK] ? EXT_WM_LCK : EXT_WM;

  always_comb begin
    ctl_n = ctl_q;
    ext_n = ext_q;
    xt_n  = xt_q;
    if (sel) begin
      if (be_i[0]) ctl_n = merge_byte(ctl_q, wdata_i[7:0], ctl_wm);
      if (be_i[1]) ext_n = merge_byte(ext_q, wdata_i[15:8], ext_wm);
      if (be_i[2]) xt_n[7:0]  = wdata_i[23:16];
      if (be_i[3]) xt_n[15:8] = wdata_i[31:24];
      if ((EXT_MB > 0) && (be_i[2] || be_i[3]) && (xt_n == XT_QUERY)) xt_n = XT_ANS;
    end
    if (ctl_n[CTL_LOCK]) ctl_n[CTL_OPEN] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= 8'h00;
      ext_q <= 8'h00;
      xt_q  <= XT_RST;
    end else begin
      ctl_q <= ctl_n;
      ext_q <= ext_n;
      xt_q  <= xt_n;
    end
  end

  assign ctl_o = ctl_q;
  assign ext_o = ext_q;
  assign xt_o  = xt_q;

  a_r9_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q[CTL_LOCK] |=> ctl_q[CTL_LOCK]);
  a_r9_open_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q[CTL_LOCK] |-> !ctl_q[CTL_OPEN]);
  a_r9_ext_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q[CTL_LOCK] |=> $stable(ext_q) && $stable(ctl_q));
  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(xt_q) && $stable(ext_q));
endmodule

// File: rtl/smm_win_decode.sv
module smm_win_decode
  import smm_pkg::*;
(
  input  logic [7:0] ctl_i,
  input  logic [7:0] ext_i,
  output logic       legacy_o,
  output logic       alias_o,
  output logic       smm_low_o,
  output logic       smm_high_o
);
  logic open, gen, high;

  assign open = ctl_i[CTL_OPEN];
  assign gen  = ctl_i[CTL_GEN];
  assign high = ext_i[EXT_HIGH];

  always_comb begin
    legacy_o   = open ? !high : 1'b1;
    alias_o    = open && high;
    smm_low_o  = gen && !high;
    smm_high_o = gen && high;
  end

  always_comb begin
    a_r3_open_split: assert (!open || (legacy_o != alias_o));
    a_r5_smm_onehot: assert (!gen || $onehot({smm_low_o, smm_high_o}));
    a_r4_closed: assert (open || (legacy_o && !alias_o));
  end
endmodule

// File: rtl/smm_tseg_map.sv
module smm_tseg_map
  import smm_pkg::*;
#(
  parameter int unsigned EXT_MB  = 16,
  parameter logic [31:0] LOW_TOP = 32'h8000_0000
) (
  input  logic [7:0]  ext_i,
  input  logic [31:0] probe_addr_i,
  input  logic        probe_smm_i,
  output logic        hole_en_o,
  output logic [31:0] base_o,
  output logic [31:0] size_o,
  output logic        hit_o,
  output logic [31:0] rdata_o
);
  localparam logic [31:0] MB = 32'h0010_0000;
  localparam logic [31:0] EXT_BYTES = 32'(EXT_MB) << 20;

  tseg_sz_e sz;
  assign sz = tseg_sz_e'(ext_i[EXT_SZ +: 2]);

  always_comb begin
    size_o = '0;
    if (ext_i[EXT_TEN]) begin
      unique case (sz)
        TSZ_1M:  size_o = MB;
        TSZ_2M:  size_o = MB << 1;
        TSZ_8M:  size_o = MB << 3;
        default: size_o = EXT_BYTES;
      endcase
    end
  end

  assign hole_en_o = size_o != '0;
  assign base_o    = LOW_TOP - size_o;
  assign hit_o     = hole_en_o && !probe_smm_i && (probe_addr_i >= base_o) && (probe_addr_i < LOW_TOP);
  assign rdata_o   = hit_o ? 32'hFFFF_FFFF : 32'h0;

  always_comb begin
    a_r7_base_sum: assert (!hole_en_o || ((base_o + size_o) == LOW_TOP));
    a_r8_no_smm_hit: assert (!(hit_o && probe_smm_i));
  end
endmodule

// File: rtl/smm_ctrl.sv
module smm_ctrl #(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h70,
  parameter int unsigned EXT_MB     = 16,
  parameter int unsigned MAX_EXT_MB = 4095,
  parameter logic [31:0] LOW_TOP    = 32'h8000_0000,
  parameter logic [31:0] ALIAS_BASE = 32'hFEDA_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic [31:0]       probe_addr_i,
  input  logic              probe_smm_i,
  output logic [7:0]        ctl_o,
  output logic [7:0]        ext_o,
  output logic [15:0]       xtseg_o,
  output logic              legacy_win_o,
  output logic              high_alias_win_o,
  output logic [31:0]       high_alias_base_o,
  output logic              smm_low_win_o,
  output logic              smm_high_win_o,
  output logic              hole_en_o,
  output logic [31:0]       tseg_base_o,
  output logic [31:0]       tseg_size_o,
  output logic              hole_hit_o,
  output logic [31:0]       hole_rdata_o
);
  if (EXT_MB > MAX_EXT_MB) begin : g_bad_strap
    $error("smm_ctrl: EXT_MB exceeds MAX_EXT_MB");
  end

  smm_cfg_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .EXT_MB(EXT_MB)) i_regs (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .be_i(cfg_be_i),
    .wdata_i(cfg_wdata_i), .ctl_o, .ext_o, .xt_o(xtseg_o)
  );

  smm_win_decode i_win (
    .ctl_i(ctl_o), .ext_i(ext_o), .legacy_o(legacy_win_o), .alias_o(high_alias_win_o),
    .smm_low_o(smm_low_win_o), .smm_high_o(smm_high_win_o)
  );

  smm_tseg_map #(.EXT_MB(EXT_MB), .LOW_TOP(LOW_TOP)) i_tseg (
    .ext_i(ext_o), .probe_addr_i, .probe_smm_i, .hole_en_o, .base_o(tseg_base_o),
    .size_o(tseg_size_o), .hit_o(hole_hit_o), .rdata_o(hole_rdata_o)
  );

  assign high_alias_base_o = ALIAS_BASE;

  a_r12_alias_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    high_alias_base_o == 32'hFEDA_0000);
endmodule

// File: tb/test_smm_ctrl.sv
`timescale 1ns/1ps
module test_smm_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [7:0] addr = 8'h70;
  logic [3:0] be = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] paddr = '0;
  logic psmm = 1'b0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] ctl0, ext0, ctl1, ext1;
  logic [15:0] xt0, xt1;
  logic leg0, al0, lo0, hi0, hen0, hit0, leg1, al1, lo1, hi1, hen1, hit1;
  logic [31:0] ab0, base0, size0, rd0, ab1, base1, size1, rd1;

  always #2.5 clk = ~clk;

  smm_ctrl i_smm_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_be_i(be),
    .cfg_wdata_i(wdata), .probe_addr_i(paddr), .probe_smm_i(psmm),
    .ctl_o(ctl0), .ext_o(ext0), .xtseg_o(xt0), .legacy_win_o(leg0), .high_alias_win_o(al0),
    .high_alias_base_o(ab0), .smm_low_win_o(lo0), .smm_high_win_o(hi0), .hole_en_o(hen0),
    .tseg_base_o(base0), .tseg_size_o(size0), .hole_hit_o(hit0), .hole_rdata_o(rd0));

  smm_ctrl #(.EXT_MB(0)) i_smm_ctrl_nostrap (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_be_i(be),
    .cfg_wdata_i(wdata), .probe_addr_i(paddr), .probe_smm_i(psmm),
    .ctl_o(ctl1), .ext_o(ext1), .xtseg_o(xt1), .legacy_win_o(leg1), .high_alias_win_o(al1),
    .high_alias_base_o(ab1), .smm_low_win_o(lo1), .smm_high_win_o(hi1), .hole_en_o(hen1),
    .tseg_base_o(base1), .tseg_size_o(size1), .hole_hit_o(hit1), .hole_rdata_o(rd1));

  typedef struct packed {
    logic [3:0]  be;
    logic [31:0] data;
    logic [7:0]  ctl;
    logic [7:0]  ext;
    logic [3:0]  win;
    logic [31:0] size;
  } vec_t;

  // win = {legacy, alias, smm_low, smm_high}
  localparam vec_t VECS [12] = '{
    '{4'h3, 32'h0000_0001, 8'h01, 8'h00, 4'b1000, 32'h0},
    '{4'h3, 32'h0000_0801, 8'h01, 8'h08, 4'b0100, 32'h0},
    '{4'h3, 32'h0000_0804, 8'h04, 8'h08, 4'b1001, 32'h0},
    '{4'h3, 32'h0000_0004, 8'h04, 8'h00, 4'b1010, 32'h0},
    '{4'h3, 32'h0000_0105, 8'h05, 8'h01, 4'b1010, 32'h0010_0000},
    '{4'h3, 32'h0000_0300, 8'h00, 8'h03, 4'b1000, 32'h0020_0000},
    '{4'h3, 32'h0000_0500, 8'h00, 8'h05, 4'b1000, 32'h0080_0000},
    '{4'h3, 32'h0000_0700, 8'h00, 8'h07, 4'b1000, 32'h0100_0000},
    '{4'h3, 32'h0000_0600, 8'h00, 8'h06, 4'b1000, 32'h0},
    '{4'h3, 32'h0000_F0F8, 8'h00, 8'h00, 4'b1000, 32'h0},
    '{4'h2, 32'h0000_09FF, 8'h00, 8'h09, 4'b1000, 32'h0010_0000},
    '{4'h1, 32'h0000_FF05, 8'h05, 8'h09, 4'b0101, 32'h0010_0000}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [3:0] b, logic [31:0] d);
    @(negedge clk);
    addr = a; be = b; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; be = 4'h0;
  endtask

  task automatic probe(logic [31:0] a, logic s);
    paddr = a; psmm = s;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctl", ctl0, 8'h00);
    chk("R1 ext", ext0, 8'h00);
    chk("R1 xt strap", xt0, 16'hFFFF);
    chk("R1 xt nostrap", xt1, 16'h0000);
    chk("R1 windows", {leg0, al0, lo0, hi0}, 4'b1000);
    chk("R1 hole", hen0, 1'b0);
    chk("R12 alias base", ab0, 32'hFEDA_0000);

    // R2..R6 table walk
    foreach (VECS[i]) begin
      wr(8'h70, VECS[i].be, VECS[i].data);
      chk($sformatf("R2 ctl v%0d", i), ctl0, VECS[i].ctl);
      chk($sformatf("R2 ext v%0d", i), ext0, VECS[i].ext);
      chk($sformatf("R3 R4 R5 win v%0d", i), {leg0, al0, lo0, hi0}, VECS[i].win);
      chk($sformatf("R6 size v%0d", i), size0, VECS[i].size);
    end

    // R2 foreign address ignored
    wr(8'h40, 4'hF, 32'hFFFF_0E00);
    chk("R2 other addr ctl", ctl0, 8'h05);
    chk("R2 other addr ext", ext0, 8'h09);
    chk("R2 other addr xt", xt0, 16'hFFFF);

    // R11 timing: not visible before the edge
    @(negedge clk);
    addr = 8'h70; be = 4'h3; wdata = 32'h0000_0500; we = 1'b1;
    #1;
    chk("R11 before edge", {leg0, al0}, 2'b01);
    @(negedge clk);
    we = 1'b0; be = 4'h0;
    chk("R11 after edge", {leg0, al0}, 2'b10);

    // R7 / R8 with 8 MB
    chk("R7 base", base0, 32'h7F80_0000);
    chk("R7 hole_en", hen0, 1'b1);
    probe(32'h7F80_0000, 1'b0);
    chk("R8 low edge hit", hit0, 1'b1);
    chk("R8 rdata ones", rd0, 32'hFFFF_FFFF);
    probe(32'h7F7F_FFFC, 1'b0);
    chk("R8 below base", hit0, 1'b0);
    probe(32'h7FFF_FFFF, 1'b0);
    chk("R8 top byte", hit0, 1'b1);
    probe(32'h8000_0000, 1'b0);
    chk("R8 at top", hit0, 1'b0);
    probe(32'h7F90_0000, 1'b1);
    chk("R8 smm no hit", hit0, 1'b0);

    // R6 strap encoding with zero strap
    wr(8'h70, 4'h2, 32'h0000_0700);
    chk("R6 strap 16MB", size0, 32'h0100_0000);
    chk("R7 strap base", base0, 32'h7F00_0000);
    chk("R6 nostrap size", size1, 32'h0);
    chk("R7 nostrap hole off", hen1, 1'b0);
    probe(32'h7FFF_0000, 1'b0);
    chk("R8 disabled hole", hit1, 1'b0);

    // R10 query
    wr(8'h70, 4'hC, 32'hFFFF_0000);
    chk("R10 answer", xt0, 16'd16);
    chk("R10 nostrap keeps code", xt1, 16'hFFFF);
    wr(8'h70, 4'hC, 32'h1234_0000);
    chk("R10 plain value", xt0, 16'h1234);
    wr(8'h70, 4'h8, 32'hAB00_0000);
    chk("R10 upper byte", xt0, 16'hAB34);

    // R9 lock
    wr(8'h70, 4'h3, 32'h0000_0105);
    chk("R9 pre-lock ctl", ctl0, 8'h05);
    wr(8'h70, 4'h1, 32'h0000_0007);
    chk("R9 open cleared", ctl0, 8'h06);
    chk("R9 locked windows", {leg0, al0, lo0, hi0}, 4'b1010);
    wr(8'h70, 4'h3, 32'h0000_0F01);
    chk("R9 ctl frozen", ctl0, 8'h06);
    chk("R9 ext frozen", ext0, 8'h01);
    wr(8'h70, 4'h1, 32'h0000_0000);
    chk("R9 lock sticky", ctl0, 8'h06);
    do_reset();
    chk("R9 reset clears lock", ctl0, 8'h00);
    wr(8'h70, 4'h1, 32'h0000_0001);
    chk("R9 writable after reset", ctl0, 8'h01);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule